// File: doc/BRIEF.md
# Two-Thread Fetch Slot Combiner

This block sits in the front end of a multithreaded core. It runs after the thread selector and the banked instruction cache. Each cycle it receives two chosen threads, labelled A and B. Each thread brings a thread identifier, a fetch address, a hit flag and an eight-word instruction block. Every word in a block carries predecode bits that mark it usable and mark it as a branch. The block builds a single eight-slot bundle for the decoder from these inputs.

Thread A has priority. It supplies words in address order and stops at any of these points:
- just after its first branch,
- at the end of its 64-byte cache line,
- before the first word whose usable bit is clear.

Thread B then fills the slots that remain, under the same three limits. Instructions are 4 bytes wide, so a line holds sixteen words. The cache has eight single-ported banks, selected by address bits [8:6]. If both threads hit and their addresses fall in the same bank, B is dropped for that cycle. The block also returns, for each thread, the address at which its next fetch should start.

The result is registered. The bundle, the per-thread counts, the clash flag and both next addresses appear one clock after the inputs are presented.

Top module: `fm_fetch_merge`

## Requirements
- R1: While reset is asserted, and on the first sample after it, every bundle slot is empty. An empty slot has valid 0, thread identifier 0 and word 0. Both counts, the clash flag and both next addresses are 0.
- R2: Slots 0 to nA-1 hold thread A's words 0 to nA-1 in order, each tagged with A's thread identifier. nA is thread A's count.
- R3: A thread takes at most min(8, 16 - pc[5:2]) words, because its line ends after word offset 15.
- R4: A thread's run stops right after the first word whose branch bit is 1. That branch word is included.
- R5: A thread's run stops just before the first word whose usable bit is 0.
- R6: A thread whose hit flag is 0 contributes no words, and its count is 0.
- R7: Thread B's words 0 to nB-1 fill slots nA to nA+nB-1, tagged with B's identifier. nB is at most 8-nA and also obeys R3 to R5 for B.
- R8: When both threads hit and pc_a[8:6] equals pc_b[8:6], the clash flag is 1 and nB is 0. If either thread misses, no clash is flagged.
- R9: Valid slots are packed from slot 0 with no gaps. Every slot from nA+nB upward is empty.
- R10: Each next address equals that thread's fetch address plus 4 times its count.
- R11: nA+nB never exceeds 8, and the number of valid slots equals nA+nB.
- R12: All outputs reflect the inputs presented one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_tid | input | 3 | Thread identifier of the first thread |
| a_pc | input | 32 | Fetch address of the first thread |
| a_hit | input | 1 | Cache hit for the first thread |
| a_words | input | 256 | Eight words of the first thread; word k in bits [32k+31:32k] |
| a_vld | input | 8 | Usable bit per word of the first thread |
| a_br | input | 8 | Branch bit per word of the first thread |
| b_tid | input | 3 | Thread identifier of the second thread |
| b_pc | input | 32 | Fetch address of the second thread |
| b_hit | input | 1 | Cache hit for the second thread |
| b_words | input | 256 | Eight words of the second thread |
| b_vld | input | 8 | Usable bit per word of the second thread |
| b_br | input | 8 | Branch bit per word of the second thread |
| bnd_valid | output | 8 | Valid bit per bundle slot |
| bnd_tid | output | 24 | Thread identifier per slot; slot s in bits [3s+2:3s] |
| bnd_word | output | 256 | Instruction word per slot; slot s in bits [32s+31:32s] |
| bnd_cnt_a | output | 4 | Words taken from the first thread |
| bnd_cnt_b | output | 4 | Words taken from the second thread |
| bank_clash | output | 1 | Both threads hit the same cache bank |
| a_next_pc | output | 32 | Next fetch address of the first thread |
| b_next_pc | output | 32 | Next fetch address of the second thread |

## Verification
The bench sweeps every line offset of thread A against every branch position, including no branch. It does this across several offsets and branch positions for thread B. This exposes any off-by-one in the line-end limit and any design that drops the branch word or keeps the word after it. Holes in the usable bits at each position catch a design that skips a hole instead of stopping at it. Other scenarios cover same-bank fetches, a miss on either side, and a miss combined with a shared bank. These catch a design that lets B through on a clash, flags a clash when one thread misses, or leaves stale slots above the packed run. These would show as duplicated or misordered words, as wrong thread tags, or as next addresses out of step with the counts.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int BLK        = 8;
  localparam int INSN_W     = 32;
  localparam int ADDR_W     = 32;
  localparam int TID_W      = 3;
  localparam int LINE_BYTES = 64;
  localparam int INSN_BYTES = 4;
  localparam int BANKS      = 8;

  localparam int LINE_INSN  = LINE_BYTES / INSN_BYTES;
  localparam int IDX_LO     = $clog2(INSN_BYTES);
  localparam int OFF_W      = $clog2(LINE_INSN);
  localparam int BANK_LO    = IDX_LO + OFF_W;
  localparam int BANK_W     = $clog2(BANKS);
  localparam int CNT_W      = $clog2(BLK + 1);
  localparam int SIDX_W     = $clog2(BLK);

  typedef struct packed {
    logic              vld;
    logic [TID_W-1:0]  tid;
    logic [INSN_W-1:0] word;
  } slot_t;

  // Words left in the line from this offset, capped at one block.
  function automatic logic [CNT_W-1:0] line_room(input logic [OFF_W-1:0] off);
    logic [OFF_W:0] left;
    left = (OFF_W+1)'(LINE_INSN) - {1'b0, off};
    if (left > (OFF_W+1)'(BLK)) return CNT_W'(BLK);
    return CNT_W'(left);
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] pc);
    return pc[BANK_LO +: BANK_W];
  endfunction

  function automatic logic [ADDR_W-1:0] advance_pc(input logic [ADDR_W-1:0] pc,
                                                   input logic [CNT_W-1:0] n);
    return pc + (ADDR_W'(n) << IDX_LO);
  endfunction
endpackage

// File: rtl/fm_take_count.sv
module fm_take_count
  import fm_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic [BLK-1:0]   vld,
  input  logic [BLK-1:0]   br,
  input  logic             hit,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] room
);
  logic stop;

  assign room = line_room(off);

  always_comb begin
    cnt  = '0;
    stop = !hit;
    for (int k = 0; k < BLK; k++) begin
      if (!stop) begin
        if (CNT_W'(k) < room && CNT_W'(k) < limit && vld[k]) begin
          cnt = CNT_W'(k + 1);
          if (br[k]) stop = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fm_bank_check.sv
module fm_bank_check
  import fm_pkg::*;
(
  input  logic [ADDR_W-1:0] pc_a,
  input  logic [ADDR_W-1:0] pc_b,
  input  logic              hit_a,
  input  logic              hit_b,
  output logic              clash
);
  logic same_bank;
  assign same_bank = (bank_of(pc_a) == bank_of(pc_b));
  assign clash     = hit_a && hit_b && same_bank;
endmodule

// File: rtl/fm_slot_pack.sv
module fm_slot_pack
  import fm_pkg::*;
(
  input  logic [TID_W-1:0]      tid_a,
  input  logic [TID_W-1:0]      tid_b,
  input  logic [BLK*INSN_W-1:0] words_a,
  input  logic [BLK*INSN_W-1:0] words_b,
  input  logic [CNT_W-1:0]      cnt_a,
  input  logic [CNT_W-1:0]      cnt_b,
  output slot_t [BLK-1:0]       slots
);
  logic [CNT_W-1:0] fill_end;
  assign fill_end = cnt_a + cnt_b;

  for (genvar s = 0; s < BLK; s++) begin : g_slot
    logic [SIDX_W-1:0] b_idx;
    slot_t             one;
    assign b_idx = SIDX_W'(s) - cnt_a[SIDX_W-1:0];
    always_comb begin
      one = '0;
      if (CNT_W'(s) < cnt_a) begin
        one.vld  = 1'b1;
        one.tid  = tid_a;
        one.word = words_a[s*INSN_W +: INSN_W];
      end else if (CNT_W'(s) < fill_end) begin
        one.vld  = 1'b1;
        one.tid  = tid_b;
        one.word = words_b[int'(b_idx)*INSN_W +: INSN_W];
      end
    end
    assign slots[s] = one;
  end
endmodule

// File: rtl/fm_fetch_merge.sv
module fm_fetch_merge
  import fm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TID_W-1:0]      a_tid,
  input  logic [ADDR_W-1:0]     a_pc,
  input  logic                  a_hit,
  input  logic [BLK*INSN_W-1:0] a_words,
  input  logic [BLK-1:0]        a_vld,
  input  logic [BLK-1:0]        a_br,
  input  logic [TID_W-1:0]      b_tid,
  input  logic [ADDR_W-1:0]     b_pc,
  input  logic                  b_hit,
  input  logic [BLK*INSN_W-1:0] b_words,
  input  logic [BLK-1:0]        b_vld,
  input  logic [BLK-1:0]        b_br,
  output logic [BLK-1:0]        bnd_valid,
  output logic [BLK*TID_W-1:0]  bnd_tid,
  output logic [BLK*INSN_W-1:0] bnd_word,
  output logic [CNT_W-1:0]      bnd_cnt_a,
  output logic [CNT_W-1:0]      bnd_cnt_b,
  output logic                  bank_clash,
  output logic [ADDR_W-1:0]     a_next_pc,
  output logic [ADDR_W-1:0]     b_next_pc
);
  // Named internal events
  logic             clash_w;
  logic [CNT_W-1:0] cnt_a_w, cnt_b_w, room_a_w, room_b_w, b_limit_w;
  slot_t [BLK-1:0]  slots_w;
  slot_t [BLK-1:0]  slots_q;

  fm_bank_check u_bank (
    .pc_a(a_pc), .pc_b(b_pc), .hit_a(a_hit), .hit_b(b_hit), .clash(clash_w)
  );

  fm_take_count u_take_a (
    .off(a_pc[IDX_LO +: OFF_W]), .vld(a_vld), .br(a_br), .hit(a_hit),
    .limit(CNT_W'(BLK)), .cnt(cnt_a_w), .room(room_a_w)
  );

  assign b_limit_w = CNT_W'(BLK) - cnt_a_w;

  fm_take_count u_take_b (
    .off(b_pc[IDX_LO +: OFF_W]), .vld(b_vld), .br(b_br), .hit(b_hit && !clash_w),
    .limit(b_limit_w), .cnt(cnt_b_w), .room(room_b_w)
  );

  fm_slot_pack u_pack (
    .tid_a(a_tid), .tid_b(b_tid), .words_a(a_words), .words_b(b_words),
    .cnt_a(cnt_a_w), .cnt_b(cnt_b_w), .slots(slots_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q    <= '0;
      bnd_cnt_a  <= '0;
      bnd_cnt_b  <= '0;
      bank_clash <= 1'b0;
      a_next_pc  <= '0;
      b_next_pc  <= '0;
    end else begin
      slots_q    <= slots_w;
      bnd_cnt_a  <= cnt_a_w;
      bnd_cnt_b  <= cnt_b_w;
      bank_clash <= clash_w;
      a_next_pc  <= advance_pc(a_pc, cnt_a_w);
      b_next_pc  <= advance_pc(b_pc, cnt_b_w);
    end
  end

  for (genvar s = 0; s < BLK; s++) begin : g_out
    assign bnd_valid[s]                  = slots_q[s].vld;
    assign bnd_tid[s*TID_W +: TID_W]     = slots_q[s].tid;
    assign bnd_word[s*INSN_W +: INSN_W]  = slots_q[s].word;
  end

  AST_ROOM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a_w <= room_a_w) && (cnt_b_w <= room_b_w)); // R3
  AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !a_hit |=> (bnd_cnt_a == '0)); // R6
  AST_CLASH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit && b_hit && a_pc[BANK_LO +: BANK_W] == b_pc[BANK_LO +: BANK_W])
      |=> (bank_clash && bnd_cnt_b == '0)); // R8
  AST_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((bnd_valid + BLK'(1)) & bnd_valid) == '0); // R9
  AST_SLOT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bnd_valid) == int'(bnd_cnt_a) + int'(bnd_cnt_b))
      && (int'(bnd_cnt_a) + int'(bnd_cnt_b) <= BLK)); // R11
  AST_NEXT_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_hit |=> (a_next_pc == $past(a_pc) + {bnd_cnt_a, 2'b00})); // R10
endmodule

// File: tb/tb_fm_fetch_merge.sv
module tb_fm_fetch_merge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]   a_tid = '0, b_tid = '0;
  logic [31:0]  a_pc = '0, b_pc = '0;
  logic         a_hit = 1'b0, b_hit = 1'b0;
  logic [255:0] a_words = '0, b_words = '0;
  logic [7:0]   a_vld = '0, a_br = '0, b_vld = '0, b_br = '0;
  logic [7:0]   bnd_valid;
  logic [23:0]  bnd_tid;
  logic [255:0] bnd_word;
  logic [3:0]   bnd_cnt_a, bnd_cnt_b;
  logic         bank_clash;
  logic [31:0]  a_next_pc, b_next_pc;

  int errors = 0;
  int checks = 0;
  int serial = 0;

  fm_fetch_merge dut (.*);

  task automatic check(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // offX: line word offset, brX: first branch index (8 = none), holeX: first unusable index (8 = none)
  task automatic run(input string tag,
                     input int offa, input int bra, input int holea, input logic ha, input int bka,
                     input int offb, input int brb, input int holeb, input logic hb, input int bkb);
    int ea, eb;
    logic clash;
    logic [31:0] pa, pb;
    serial++;
    @(negedge clk);
    pa = 32'h0004_0000 | (bka << 6) | (offa << 2);
    pb = 32'h0009_0000 | (bkb << 6) | (offb << 2);
    a_pc = pa; b_pc = pb; a_hit = ha; b_hit = hb;
    a_tid = 3'(serial % 8); b_tid = 3'((serial + 3) % 8);
    a_br = '0; b_br = '0; a_vld = '1; b_vld = '1;
    for (int k = 0; k < 8; k++) begin
      a_words[k*32 +: 32] = {8'hA1, 16'(serial), 8'(k)};
      b_words[k*32 +: 32] = {8'hB2, 16'(serial), 8'(k)};
      if (k == bra) a_br[k] = 1'b1;
      if (k == brb) b_br[k] = 1'b1;
      if (k >= holea) a_vld[k] = 1'b0;
      if (k >= holeb) b_vld[k] = 1'b0;
    end
    // reference count, walked word by word
    clash = ha && hb && (bka == bkb);
    ea = 0;
    if (ha) begin
      for (int k = 0; k < 8; k++) begin
        if (offa + k > 15 || k >= holea) break;
        ea++;
        if (k == bra) break;
      end
    end
    eb = 0;
    if (hb && !clash) begin
      for (int k = 0; k < 8; k++) begin
        if (ea + eb == 8 || offb + k > 15 || k >= holeb) break;
        eb++;
        if (k == brb) break;
      end
    end
    @(negedge clk); // R12: one edge later
    check(tag, "count A", 64'(bnd_cnt_a), 64'(ea));
    check(tag, "count B (R7)", 64'(bnd_cnt_b), 64'(eb));
    check(clash ? "R8" : tag, "clash flag", 64'(bank_clash), 64'(clash));
    check("R10", "next pc A", 64'(a_next_pc), 64'(pa + 32'(4 * ea)));
    check("R10", "next pc B", 64'(b_next_pc), 64'(pb + 32'(4 * eb)));
    for (int s = 0; s < 8; s++) begin
      logic [35:0] exp_slot, got_slot;
      string stag;
      if (s < ea) begin
        exp_slot = {1'b1, a_tid, a_words[s*32 +: 32]}; stag = "R2";
      end else if (s < ea + eb) begin
        exp_slot = {1'b1, b_tid, b_words[(s-ea)*32 +: 32]}; stag = "R7";
      end else begin
        exp_slot = '0; stag = "R9";
      end
      got_slot = {bnd_valid[s], bnd_tid[s*3 +: 3], bnd_word[s*32 +: 32]};
      check(stag, $sformatf("slot %0d", s), 64'(got_slot), 64'(exp_slot));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid", 64'(bnd_valid), 64'd0);
    check("R1", "words", 64'(bnd_word[63:0]), 64'd0);
    check("R1", "counts", 64'({bnd_cnt_a, bnd_cnt_b, bank_clash}), 64'd0);
    check("R1", "next pcs", {a_next_pc, b_next_pc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "first sample after reset", 64'({bnd_valid, bnd_cnt_a, bnd_cnt_b}), 64'd0);

    // R3 R4 R7 R11: line offset x branch position sweep, separate banks
    for (int oa = 0; oa < 16; oa++)
      for (int ba = 0; ba <= 8; ba++)
        foreach (run_offs_b[i])
          for (int bb = 2; bb <= 8; bb += 6)
            run("R3_R4", oa, ba, 8, 1'b1, 1, run_offs_b[i], bb, 8, 1'b1, 5);

    // R5: holes in usable bits
    for (int h = 0; h < 8; h++) begin
      run("R5", 0, 8, h, 1'b1, 2, 0, 8, 8, 1'b1, 3);
      run("R5", 2, 8, 3, 1'b1, 2, 0, 8, h, 1'b1, 3);
    end

    // R6: misses
    for (int o = 0; o < 16; o += 3) begin
      run("R6", o, 8, 8, 1'b0, 4, o, 8, 8, 1'b1, 6);
      run("R6", o, 8, 8, 1'b1, 4, 0, 8, 8, 1'b0, 6);
      run("R6", o, 1, 8, 1'b0, 4, 0, 8, 8, 1'b0, 6);
    end

    // R8: shared bank, and shared bank with one miss
    for (int bk = 0; bk < 8; bk++) begin
      run("R8", 12, 8, 8, 1'b1, bk, 0, 8, 8, 1'b1, bk);
      run("R8", 0, 2, 8, 1'b1, bk, 4, 8, 8, 1'b1, bk);
      run("R8", 0, 2, 8, 1'b0, bk, 4, 8, 8, 1'b1, bk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int run_offs_b [4] = '{0, 3, 9, 15};
endmodule